// File: doc/BRIEF.md
# Configuration Bitstream Command Parser

This block takes an FPGA configuration byte stream, one byte per accepted transfer, and turns it into register updates and memory-bank writes. Until it sees the 32-bit synchronisation word, every incoming byte is discarded, including the comment preamble. After that it reads command bytes. The high nibble of a command byte is the opcode and the low nibble is the number of argument bytes that follow. The argument bytes form a big-endian value, and the command takes effect when its last argument byte is accepted.

Opcode 0 takes its argument as a sub-command. Two of the sub-commands start a bulk data block. The number of bytes in the block comes from the bank width and height that were loaded earlier. Each data byte goes out on a write port, tagged with the bank, the memory type, and the row and column of its first bit. Two zero bytes must follow every block. A 16-bit CRC runs over the synchronised stream and is checked on command. Wakeup produces a single-cycle pulse and sets a done flag.

Both streams use valid/ready. A byte on `in_data` is taken in any cycle where `in_valid` and `in_ready` are both high. A write on the `mw_*` port completes in a cycle where `mw_valid` and `mw_ready` are both high. While a write is held (`mw_valid` high and `mw_ready` low), the write fields stay frozen and `in_ready` is low, so the stall reaches the input in the same cycle.

Top module: `cfg_stream_parser`

## Requirements
- R1: After reset all flags and configuration outputs are zero, `synced` is low, `mw_valid` is low and `in_ready` is high.
- R2: Bytes are ignored until the last four accepted bytes equal 0x7E,0xAA,0x99,0x7E in arrival order. Partial or overlapping matches, such as a doubled 0x7E, still lock. At that point `synced` rises and the CRC is seeded to 0xFFFF.
- R3: Command byte bits 7:4 are the opcode and bits 3:0 are the argument length in bytes. Arguments arrive MSB first. The register opcodes are:
  - 1 loads `bank_sel`
  - 4 loads `boot_addr`
  - 5 loads `osc_range` (0 low, 1 medium, 2 high)
  - 6, 7 and 8 load the 16-bit `bank_width`, `bank_height` and `bank_offset`
- R4: Opcode 9 changes the boot mode. Value 16 sets `cold_boot_en`, value 32 sets `warm_boot_en`, and value 0 clears `warm_boot_en`.
- R5: Sub-command 1 starts a configuration-memory block (`mw_bram`=0) and sub-command 3 starts a block-RAM block (`mw_bram`=1). The block is width*height/8 data bytes, each issued as one write in arrival order. The first write goes to row `bank_offset`, column 0. The column then advances by 8, and on reaching the width it wraps (column minus width) onto the next row.
- R6: After a data block, exactly two bytes must be zero. A nonzero byte there sets the sticky `fmt_err` and drops `synced`. Later commands have no effect until the synchronisation word is found again.
- R7: The CRC uses polynomial 0x1021, shifted MSB first with no padding. It covers every byte accepted while synced, up to and including the check command's arguments. Sub-command 5 reseeds it to 0xFFFF. On opcode 2 the check passes if the register is then zero; otherwise the sticky `crc_err` is set.
- R8: Sub-command 6 makes `wakeup` high for exactly one cycle and sets the sticky `done`.
- R9: Sub-commands 2 and 4 set the sticky `unsup` flag, consume no data, and the parser stays synced.
- R10: Opcodes 3 and 10–15, and sub-commands other than 1, 2, 3, 4, 5, 6 and 8, set `fmt_err` and drop `synced`.
- R11: While `mw_valid` is high and `mw_ready` low, `in_ready` is low and the write fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser can take a byte |
| mw_valid | output | 1 | Memory write pending |
| mw_ready | input | 1 | Memory side accepts write |
| mw_bram | output | 1 | 1 = block RAM, 0 = configuration memory |
| mw_bank | output | 2 | Target bank |
| mw_row | output | 16 | Row of the byte's first bit |
| mw_col | output | 16 | Column of the byte's first bit |
| mw_data | output | 8 | Eight bits, MSB first |
| bank_sel | output | 2 | Current bank number |
| bank_width | output | 16 | Bank width in bits |
| bank_height | output | 16 | Rows per data block |
| bank_offset | output | 16 | Starting row |
| boot_addr | output | 24 | Boot address |
| osc_range | output | 2 | Oscillator range code |
| cold_boot_en | output | 1 | Cold boot enabled |
| warm_boot_en | output | 1 | Warm boot enabled |
| synced | output | 1 | Synchronisation word found |
| done | output | 1 | Wakeup seen (sticky) |
| wakeup | output | 1 | One-cycle wakeup pulse |
| crc_err | output | 1 | CRC check failed (sticky) |
| fmt_err | output | 1 | Format violation (sticky) |
| unsup | output | 1 | Read sub-command seen (sticky) |

## Verification
Two functions can overlap in one cycle: a held memory write from the last data byte, and the parser's move into the trailing-zero and command phases. The bench provokes this by driving `mw_ready` from a pseudo-random pattern during a block, so the last write is still waiting while the next bytes are offered. Each captured write is compared with the row and column computed from R5. Input bytes must stall while the write is held, and the CRC check that follows the block must still pass.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
  typedef enum logic [2:0] {ST_HUNT, ST_CMD, ST_PAY, ST_DATA, ST_TRAIL} pstate_e;

  localparam logic [31:0] SYNC_WORD = 32'h7EAA_997E;

  localparam logic [3:0] OP_SUB  = 4'd0;
  localparam logic [3:0] OP_BANK = 4'd1;
  localparam logic [3:0] OP_CRC  = 4'd2;
  localparam logic [3:0] OP_BOOT = 4'd4;
  localparam logic [3:0] OP_OSC  = 4'd5;
  localparam logic [3:0] OP_WID  = 4'd6;
  localparam logic [3:0] OP_HGT  = 4'd7;
  localparam logic [3:0] OP_OFS  = 4'd8;
  localparam logic [3:0] OP_MODE = 4'd9;

  localparam logic [31:0] SUB_WCFG   = 32'd1;
  localparam logic [31:0] SUB_RD_A   = 32'd2;
  localparam logic [31:0] SUB_WRAM   = 32'd3;
  localparam logic [31:0] SUB_RD_B   = 32'd4;
  localparam logic [31:0] SUB_CRCRST = 32'd5;
  localparam logic [31:0] SUB_WAKE   = 32'd6;
  localparam logic [31:0] SUB_REBOOT = 32'd8;

  localparam logic [31:0] MODE_WARM_OFF = 32'd0;
  localparam logic [31:0] MODE_COLD_ON  = 32'd16;
  localparam logic [31:0] MODE_WARM_ON  = 32'd32;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/cfgp_sync_hunt.sv
`timescale 1ns/1ps
module cfgp_sync_hunt
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       shift,
  input  logic [7:0] din,
  output logic       hit
);
  logic [23:0] hist_q;

  assign hit = ({hist_q, din} == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) hist_q <= '0;
    else if (shift)    hist_q <= {hist_q[15:0], din};
  end

  AST_HIST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hist_q == 24'd0)) else $error("history not cleared"); // R2
endmodule

// File: rtl/cfgp_crc16.sv
`timescale 1ns/1ps
module cfgp_crc16
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc_q,
  output logic [15:0] crc_nx
);
  assign crc_nx = crc16_step(crc_q, din);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (init) crc_q <= CRC_SEED;
    else if (upd)  crc_q <= crc_nx;
  end

  AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == CRC_SEED)) else $error("crc not seeded"); // R7
  AST_CRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !upd) |=> $stable(crc_q)) else $error("crc moved while idle"); // R7
endmodule

// File: rtl/cfgp_addr_gen.sv
`timescale 1ns/1ps
module cfgp_addr_gen #(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [DIM_W-1:0] offset,
  output logic [DIM_W-1:0] row,
  output logic [DIM_W-1:0] col,
  output logic             empty,
  output logic             last,
  output logic             active
);
  localparam int AREA_W = 2 * DIM_W;
  localparam int CNT_W  = AREA_W - 3;

  logic [AREA_W-1:0] area;
  logic [CNT_W-1:0]  count, rem_q;
  logic [DIM_W-1:0]  row_q, col_q;
  logic [DIM_W:0]    col_adv;

  assign area    = AREA_W'(width) * AREA_W'(height);
  assign count   = area[AREA_W-1:3];
  assign empty   = (count == '0);
  assign active  = (rem_q != '0);
  assign last    = (rem_q == CNT_W'(1));
  assign row     = row_q;
  assign col     = col_q;
  assign col_adv = {1'b0, col_q} + (DIM_W+1)'(8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      rem_q <= '0;
    end else if (start) begin
      row_q <= offset;
      col_q <= '0;
      rem_q <= count;
    end else if (step && active) begin
      rem_q <= rem_q - CNT_W'(1);
      if (col_adv >= {1'b0, width}) begin
        col_q <= DIM_W'(col_adv - {1'b0, width});
        row_q <= row_q + DIM_W'(1);
      end else begin
        col_q <= DIM_W'(col_adv);
      end
    end
  end

  AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (col_q < width)) else $error("column beyond width"); // R5
  AST_ROW_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && active && !start) |=> (row_q >= $past(row_q))) else $error("row went back"); // R5
endmodule

// File: rtl/cfg_stream_parser.sv
`timescale 1ns/1ps
module cfg_stream_parser
  import cfgp_pkg::*;
#(
  parameter int DIM_W   = 16,
  parameter int BANK_W  = 2,
  parameter int BADDR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic               mw_valid,
  input  logic               mw_ready,
  output logic               mw_bram,
  output logic [BANK_W-1:0]  mw_bank,
  output logic [DIM_W-1:0]   mw_row,
  output logic [DIM_W-1:0]   mw_col,
  output logic [7:0]         mw_data,
  output logic [BANK_W-1:0]  bank_sel,
  output logic [DIM_W-1:0]   bank_width,
  output logic [DIM_W-1:0]   bank_height,
  output logic [DIM_W-1:0]   bank_offset,
  output logic [BADDR_W-1:0] boot_addr,
  output logic [1:0]         osc_range,
  output logic               cold_boot_en,
  output logic               warm_boot_en,
  output logic               synced,
  output logic               done,
  output logic               wakeup,
  output logic               crc_err,
  output logic               fmt_err,
  output logic               unsup
);
  pstate_e     state_q;
  logic [3:0]  op_q, left_q;
  logic [23:0] pay_q;
  logic        trail_q;
  logic        acc, sync_hit;
  logic        exec_fire, known, sub_known;
  logic [3:0]  exec_op;
  logic [31:0] exec_val;
  logic        crc_init, crc_upd;
  logic [15:0] crc_q, crc_nx;
  logic        ag_start, ag_step, ag_empty, ag_last, ag_active;
  logic [DIM_W-1:0] ag_row, ag_col;

  assign in_ready = !mw_valid || mw_ready;
  assign acc      = in_valid && in_ready;
  assign synced   = (state_q != ST_HUNT);

  // command execution happens on the byte that completes the command
  always_comb begin
    exec_fire = 1'b0;
    exec_op   = op_q;
    exec_val  = {pay_q, in_data};
    if (acc && state_q == ST_CMD && in_data[3:0] == 4'd0) begin
      exec_fire = 1'b1;
      exec_op   = in_data[7:4];
      exec_val  = '0;
    end else if (acc && state_q == ST_PAY && left_q == 4'd1) begin
      exec_fire = 1'b1;
    end
    sub_known = (exec_val == SUB_WCFG)   || (exec_val == SUB_RD_A) ||
                (exec_val == SUB_WRAM)   || (exec_val == SUB_RD_B) ||
                (exec_val == SUB_CRCRST) || (exec_val == SUB_WAKE) ||
                (exec_val == SUB_REBOOT);
    unique case (exec_op)
      OP_SUB:  known = sub_known;
      OP_BANK, OP_CRC, OP_BOOT, OP_OSC,
      OP_WID, OP_HGT, OP_OFS, OP_MODE: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  assign crc_upd  = acc && (state_q != ST_HUNT);
  assign crc_init = (acc && state_q == ST_HUNT && sync_hit) ||
                    (exec_fire && exec_op == OP_SUB && exec_val == SUB_CRCRST);
  assign ag_start = exec_fire && exec_op == OP_SUB &&
                    (exec_val == SUB_WCFG || exec_val == SUB_WRAM);
  assign ag_step  = acc && (state_q == ST_DATA);

  cfgp_sync_hunt u_sync (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_HUNT),
    .shift(acc && state_q == ST_HUNT), .din(in_data), .hit(sync_hit)
  );

  cfgp_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
    .din(in_data), .crc_q(crc_q), .crc_nx(crc_nx)
  );

  cfgp_addr_gen #(.DIM_W(DIM_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(ag_start), .step(ag_step),
    .width(bank_width), .height(bank_height), .offset(bank_offset),
    .row(ag_row), .col(ag_col), .empty(ag_empty), .last(ag_last),
    .active(ag_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_HUNT;
      op_q         <= '0;
      left_q       <= '0;
      pay_q        <= '0;
      trail_q      <= 1'b0;
      bank_sel     <= '0;
      bank_width   <= '0;
      bank_height  <= '0;
      bank_offset  <= '0;
      boot_addr    <= '0;
      osc_range    <= '0;
      cold_boot_en <= 1'b0;
      warm_boot_en <= 1'b0;
      done         <= 1'b0;
      wakeup       <= 1'b0;
      crc_err      <= 1'b0;
      fmt_err      <= 1'b0;
      unsup        <= 1'b0;
      mw_bram      <= 1'b0;
      mw_bank      <= '0;
    end else begin
      wakeup <= 1'b0;
      unique case (state_q)
        ST_HUNT: if (acc && sync_hit) state_q <= ST_CMD;
        ST_CMD: if (acc) begin
          op_q   <= in_data[7:4];
          left_q <= in_data[3:0];
          pay_q  <= '0;
          if (in_data[3:0] != 4'd0) state_q <= ST_PAY;
        end
        ST_PAY: if (acc) begin
          pay_q  <= {pay_q[15:0], in_data};
          left_q <= left_q - 4'd1;
          if (left_q == 4'd1) state_q <= ST_CMD;
        end
        ST_DATA: if (acc && ag_last) begin
          state_q <= ST_TRAIL;
          trail_q <= 1'b0;
        end
        ST_TRAIL: if (acc) begin
          if (in_data != 8'd0) begin
            fmt_err <= 1'b1;
            state_q <= ST_HUNT;
          end else if (trail_q) begin
            state_q <= ST_CMD;
          end else begin
            trail_q <= 1'b1;
          end
        end
        default: state_q <= ST_HUNT;
      endcase

      if (exec_fire) begin
        if (!known) begin
          fmt_err <= 1'b1;
          state_q <= ST_HUNT;
        end else begin
          unique case (exec_op)
            OP_BANK: bank_sel    <= exec_val[BANK_W-1:0];
            OP_BOOT: boot_addr   <= exec_val[BADDR_W-1:0];
            OP_OSC:  osc_range   <= exec_val[1:0];
            OP_WID:  bank_width  <= exec_val[DIM_W-1:0];
            OP_HGT:  bank_height <= exec_val[DIM_W-1:0];
            OP_OFS:  bank_offset <= exec_val[DIM_W-1:0];
            OP_CRC:  if (crc_nx != 16'd0) crc_err <= 1'b1;
            OP_MODE: begin
              if (exec_val == MODE_WARM_OFF) warm_boot_en <= 1'b0;
              if (exec_val == MODE_COLD_ON)  cold_boot_en <= 1'b1;
              if (exec_val == MODE_WARM_ON)  warm_boot_en <= 1'b1;
            end
            OP_SUB: begin
              if (exec_val == SUB_RD_A || exec_val == SUB_RD_B) unsup <= 1'b1;
              if (exec_val == SUB_WAKE) begin
                wakeup <= 1'b1;
                done   <= 1'b1;
              end
              if (ag_start) begin
                mw_bram <= (exec_val == SUB_WRAM);
                mw_bank <= bank_sel;
                trail_q <= 1'b0;
                state_q <= ag_empty ? ST_TRAIL : ST_DATA;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mw_valid <= 1'b0;
      mw_row   <= '0;
      mw_col   <= '0;
      mw_data  <= '0;
    end else if (ag_step) begin
      mw_valid <= 1'b1;
      mw_row   <= ag_row;
      mw_col   <= ag_col;
      mw_data  <= in_data;
    end else if (mw_ready) begin
      mw_valid <= 1'b0;
    end
  end

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_data) && $stable(mw_row) && $stable(mw_col)))
    else $error("held write changed"); // R11
  AST_WRITE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_valid) |-> ($past(state_q) == ST_DATA)) else $error("write outside data"); // R5
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |=> !wakeup) else $error("wakeup too long"); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done) else $error("done dropped"); // R8
  AST_CRCERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> crc_err) else $error("crc_err dropped"); // R7
  AST_FMTERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err) else $error("fmt_err dropped"); // R6
  AST_ADDR_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_DATA) |-> !ag_active) else $error("address walk outside data"); // R5
endmodule

// File: tb/cfg_stream_parser_tb.sv
`timescale 1ns/1ps
module cfg_stream_parser_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, mw_ready = 1'b1;
  logic [7:0] in_data = 8'd0;
  logic in_ready, mw_valid, mw_bram;
  logic [1:0] mw_bank, bank_sel, osc_range;
  logic [15:0] mw_row, mw_col, bank_width, bank_height, bank_offset;
  logic [7:0] mw_data;
  logic [23:0] boot_addr;
  logic cold_boot_en, warm_boot_en, synced, done, wakeup, crc_err, fmt_err, unsup;

  cfg_stream_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_bram(mw_bram), .mw_bank(mw_bank),
    .mw_row(mw_row), .mw_col(mw_col), .mw_data(mw_data), .bank_sel(bank_sel),
    .bank_width(bank_width), .bank_height(bank_height), .bank_offset(bank_offset),
    .boot_addr(boot_addr), .osc_range(osc_range), .cold_boot_en(cold_boot_en),
    .warm_boot_en(warm_boot_en), .synced(synced), .done(done), .wakeup(wakeup),
    .crc_err(crc_err), .fmt_err(fmt_err), .unsup(unsup)
  );

  int n_cmp = 0, n_bad = 0;
  logic [15:0] tb_crc = 16'hFFFF;

  // stall pattern for the write port, changed only at rising edges
  logic stall_en = 1'b0;
  logic [7:0] lf = 8'h5B;
  always @(posedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mw_ready <= stall_en ? lf[0] : 1'b1;
  end

  // capture completed writes and wakeup pulses
  logic cap_clr = 1'b0;
  int cap_n = 0, wake_cnt = 0;
  logic [7:0]  cap_d [8];
  logic [15:0] cap_r [8], cap_c [8];
  logic [1:0]  cap_b [8];
  logic        cap_m [8];
  always @(posedge clk) begin
    if (cap_clr) cap_n <= 0;
    else if (rst_n && mw_valid && mw_ready && cap_n < 8) begin
      cap_d[cap_n] <= mw_data; cap_r[cap_n] <= mw_row; cap_c[cap_n] <= mw_col;
      cap_b[cap_n] <= mw_bank; cap_m[cap_n] <= mw_bram; cap_n <= cap_n + 1;
    end
    if (rst_n && wakeup) wake_cnt <= wake_cnt + 1;
  end

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) r = (r[15] ^ d[i]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
    tb_crc = crc_ref(tb_crc, b);
  endtask

  task automatic send_cmd(input logic [7:0] cb, input logic [23:0] v);
    send_byte(cb);
    for (int k = int'(cb[3:0]) - 1; k >= 0; k--) send_byte(v[8*k +: 8]);
  endtask

  task automatic send_sync();
    send_byte(8'h7E); send_byte(8'hAA); send_byte(8'h99); send_byte(8'h7E);
    tb_crc = 16'hFFFF;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic crc_check(input logic corrupt);
    logic [15:0] c;
    send_byte(8'h22);
    c = tb_crc;
    send_byte(c[15:8] ^ {7'd0, corrupt});
    send_byte(c[7:0]);
  endtask

  // register command vectors: {command byte, argument, expected output}
  localparam int NV = 10;
  localparam logic [55:0] VEC [NV] = '{
    {8'h11, 24'h000002, 24'h000002},
    {8'h43, 24'h123456, 24'h123456},
    {8'h51, 24'h000002, 24'h000002},
    {8'h62, 24'h000010, 24'h000010},
    {8'h72, 24'h000002, 24'h000002},
    {8'h82, 24'h000005, 24'h000005},
    {8'h91, 24'h000010, 24'h000002},
    {8'h91, 24'h000020, 24'h000003},
    {8'h91, 24'h000000, 24'h000002},
    {8'h51, 24'h000001, 24'h000001}
  };

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [23:0] act;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", in_ready, 1);
    chk("R1 mw_valid", mw_valid, 0);
    chk("R1 flags", {synced, done, wakeup, crc_err, fmt_err, unsup}, 0);
    chk("R1 regs", {bank_sel, osc_range, cold_boot_en, warm_boot_en, boot_addr}, 0);

    // R2 preamble and a stray command are ignored before sync
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h41); send_byte(8'h00);
    send_byte(8'h00); send_byte(8'hFF);
    send_cmd(8'h11, 24'h3);
    chk("R2 unsynced", synced, 0);
    chk("R2 bank ignored", bank_sel, 0);
    send_byte(8'h7E);
    send_sync();
    chk("R2 synced after doubled 7E", synced, 1);

    // R3 R4 register vectors
    for (int i = 0; i < NV; i++) begin
      send_cmd(VEC[i][55:48], VEC[i][47:24]);
      unique case (VEC[i][55:52])
        4'h1: act = 24'(bank_sel);
        4'h4: act = boot_addr;
        4'h5: act = 24'(osc_range);
        4'h6: act = 24'(bank_width);
        4'h7: act = 24'(bank_height);
        4'h8: act = 24'(bank_offset);
        default: act = {22'd0, cold_boot_en, warm_boot_en};
      endcase
      chk((VEC[i][55:52] == 4'h9) ? "R4 boot mode" : "R3 register", act, VEC[i][23:0]);
    end

    // R5 R11 block RAM data under back-pressure
    @(negedge clk); cap_clr = 1'b1; @(negedge clk); cap_clr = 1'b0;
    stall_en = 1'b1;
    send_cmd(8'h01, 24'h3);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h0F); send_byte(8'hF0);
    send_byte(8'h00); send_byte(8'h00);
    stall_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 write count", cap_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R11 R5 data order", cap_d[k], (k == 0) ? 8'hA5 : (k == 1) ? 8'h3C : (k == 2) ? 8'h0F : 8'hF0);
      chk("R5 row", cap_r[k], 16'(5 + k / 2));
      chk("R5 col", cap_c[k], 16'((k % 2) * 8));
      chk("R5 bank/bram", {cap_b[k], cap_m[k]}, 3'b101);
    end
    chk("R6 zeros accepted", {fmt_err, synced}, 2'b01);

    // R7 good check covering data
    crc_check(1'b0);
    chk("R7 good crc", crc_err, 0);

    // R8 wakeup
    send_cmd(8'h01, 24'h6);
    chk("R8 done", done, 1);
    repeat (3) @(negedge clk);
    chk("R8 single pulse", wake_cnt, 1);

    // R9 read sub-commands
    send_cmd(8'h01, 24'h2);
    chk("R9 unsup", unsup, 1);
    send_cmd(8'h01, 24'h4);
    send_cmd(8'h51, 24'h0);
    chk("R9 still parsing", {synced, osc_range}, 3'b100);

    // R7 reseed then a corrupted check
    send_cmd(8'h01, 24'h5);
    tb_crc = 16'hFFFF;
    crc_check(1'b0);
    chk("R7 after reseed", crc_err, 0);
    crc_check(1'b1);
    chk("R7 bad crc", crc_err, 1);

    // R5 R6 width not a multiple of 8, bad trailer
    do_reset();
    send_sync();
    send_cmd(8'h62, 24'd12); send_cmd(8'h72, 24'd2);
    @(negedge clk); cap_clr = 1'b1; @(negedge clk); cap_clr = 1'b0;
    send_cmd(8'h01, 24'h1);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    send_byte(8'h00); send_byte(8'h07);
    repeat (2) @(negedge clk);
    chk("R5 wrap count", cap_n, 3);
    chk("R5 wrap first", {cap_r[0], cap_c[0], 7'd0, cap_m[0]}, {16'd0, 16'd0, 8'd0});
    chk("R5 wrap second", {cap_r[1], cap_c[1]}, {16'd0, 16'd8});
    chk("R5 wrap third", {cap_r[2], cap_c[2]}, {16'd1, 16'd4});
    chk("R6 bad trailer", {fmt_err, synced}, 2'b10);
    send_cmd(8'h11, 24'h1);
    chk("R6 ignored after error", bank_sel, 0);
    send_sync();
    send_cmd(8'h11, 24'h1);
    chk("R6 resync works", {bank_sel, fmt_err}, 3'b011);

    // R10 unknown opcode and unknown sub-command
    do_reset();
    send_sync();
    send_byte(8'hA0);
    chk("R10 bad opcode", {fmt_err, synced}, 2'b10);
    do_reset();
    send_sync();
    send_cmd(8'h01, 24'h7);
    chk("R10 bad sub", {fmt_err, synced}, 2'b10);

    finish_run();
  end
endmodule